// File: doc/BRIEF.md
# Consecutive-Breach Boost Frequency Controller

This block holds a frequency boost value, in kHz, that a memory-clock governor adds on top of its demand estimate. An activity monitor reports two kinds of event. An upper event means the average stayed above its high watermark for several samples. A lower event means it stayed below its low watermark. On each event the controller rescales the boost by a configured percentage. It also recomputes the two enable flags that decide which of the monitor's consecutive-watermark interrupts stay armed.

An upper event grows the boost geometrically and then adds a fixed step. The result is capped at the maximum clock frequency, and reaching the cap disarms further upper interrupts. A lower event shrinks the boost geometrically. Once the boost falls under half a step it becomes zero, and further lower interrupts are disarmed. The divide by one hundred runs on a shared bit-serial divider, so each update takes several dozen cycles. Events that arrive in the meantime wait in a short queue and are handled in arrival order. Each finished update is marked by a one-cycle `done_o` pulse.

Top module: `boost_ctl`

## Requirements
- R1: On an upper event whose result stays below `fmax_i`, the new boost is `min(old*up_coeff_i/100, 2^32-1) + 16000` (integer divide). `below_en_o` becomes 1 and `above_en_o` keeps its value.
- R2: On an upper event whose scaled-plus-step result is greater than or equal to `fmax_i`, the boost becomes `fmax_i`, `above_en_o` becomes 0 and `below_en_o` becomes 1.
- R3: On a lower event the new boost is `min(old*dn_coeff_i/100, 2^32-1)` and `above_en_o` becomes 1.
- R4: If that decayed value is below 8000, the boost becomes 0 and `below_en_o` becomes 0. Otherwise `below_en_o` keeps its value.
- R5: When `brk_up_i` and `brk_dn_i` are both high in one cycle, exactly one upper event is recorded.
- R6: The percentage product, after the divide by 100, saturates at 2^32-1 before the step is added or the snap test is made.
- R7: After reset, and one cycle after `restart_i` is sampled high, the outputs are boost 0, `above_en_o` 1 and `below_en_o` 0. Pending and in-flight events are discarded, and so is any event strobed in the same cycle as the restart.
- R8: Events that arrive while an update is running are queued up to 4 deep and processed in arrival order. A strobe that finds the queue full is dropped, so a burst of consecutive strobes from idle yields at most 5 updates.
- R9: `done_o` is a one-cycle pulse per processed event. The boost and enables change only in the cycle `done_o` is high, or after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| restart_i | input | 1 | Synchronous restart of the boost state |
| brk_up_i | input | 1 | Consecutive-upper breach strobe |
| brk_dn_i | input | 1 | Consecutive-lower breach strobe |
| up_coeff_i | input | 16 | Upper growth factor in percent |
| dn_coeff_i | input | 16 | Lower decay factor in percent |
| fmax_i | input | 32 | Maximum frequency in kHz |
| boost_o | output | 32 | Current boost in kHz |
| above_en_o | output | 1 | Consecutive-above interrupt enable |
| below_en_o | output | 1 | Consecutive-below interrupt enable |
| done_o | output | 1 | One-cycle pulse when an update has been applied |

## Verification
The hardest state to reach from the ports is 32-bit saturation of the scaled product. It needs a boost near the top of the range and a coefficient far above one hundred. The stimulus reaches it by using an unlimited `fmax_i` and a large up coefficient, so the boost grows to the cap in a handful of upper events, and then applies a huge down coefficient. Queue overflow is reached with back-to-back strobe bursts from idle that are longer than the queue. Restart is tested in the middle of an update. The rest of the space is covered by random bursts with random coefficients and caps.

// File: rtl/boost_ctl_pkg.sv
package boost_ctl_pkg;
  typedef enum logic {
    EV_LOWER = 1'b0,
    EV_UPPER = 1'b1
  } breach_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SCALE = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/boost_ctl_evq.sv
module boost_ctl_evq
  import boost_ctl_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    flush_i,
  input  logic    push_i,
  input  breach_e push_kind_i,
  input  logic    pop_i,
  output logic    empty_o,
  output breach_e head_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  breach_e        slot_q [DEPTH];
  logic [PW-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]  rd_ptr_q, rd_ptr_d;
  logic [NW-1:0]  fill_q, fill_d;
  logic           full;
  logic           wr_en;
  logic           rd_en;

  assign full    = (fill_q == NW'(DEPTH));
  assign empty_o = (fill_q == '0);
  assign rd_en   = pop_i && !empty_o;
  assign wr_en   = push_i && (!full || rd_en);
  assign head_o  = slot_q[rd_ptr_q];

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + PW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    fill_d   = fill_q;
    if (flush_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      fill_d   = '0;
    end else begin
      if (wr_en) wr_ptr_d = wrap_inc(wr_ptr_q);
      if (rd_en) rd_ptr_d = wrap_inc(rd_ptr_q);
      case ({wr_en, rd_en})
        2'b10:   fill_d = fill_q + NW'(1);
        2'b01:   fill_d = fill_q - NW'(1);
        default: fill_d = fill_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && !flush_i && (wr_ptr_q == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[g] <= push_kind_i;
    end
  end

  // R8: occupancy never exceeds the configured depth
  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= NW'(DEPTH));

  // R8: a full queue with no pop keeps its occupancy
  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_i && !flush_i) |=> full);
endmodule

// File: rtl/boost_ctl_div.sv
module boost_ctl_div #(
  parameter int DW      = 48,
  parameter int DIVISOR = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort_i,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] quot_o
);
  localparam int RW   = $clog2(DIVISOR);
  localparam int CNTW = $clog2(DW + 1);

  logic [DW-1:0]   q_q, q_d;
  logic [RW-1:0]   rem_q, rem_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            busy_q, busy_d;
  logic            done_q, done_d;
  logic [RW:0]     trial;
  logic            fits;

  assign trial = {rem_q, q_q[DW-1]};
  assign fits  = (trial >= (RW+1)'(DIVISOR));

  always_comb begin
    q_d    = q_q;
    rem_d  = rem_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (abort_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start_i) begin
      q_d    = dividend_i;
      rem_d  = '0;
      cnt_d  = CNTW'(DW);
      busy_d = 1'b1;
    end else if (busy_q) begin
      q_d   = {q_q[DW-2:0], fits};
      rem_d = fits ? RW'(trial - (RW+1)'(DIVISOR)) : trial[RW-1:0];
      cnt_d = cnt_q - CNTW'(1);
      if (cnt_q == CNTW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      q_q    <= q_d;
      rem_q  <= rem_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = q_q;

  // R6: partial remainder stays a valid residue while dividing
  a_r6_rem_residue: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < RW'(DIVISOR)));

  // R9: completion is never reported while still iterating
  a_r9_div_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
endmodule

// File: rtl/boost_ctl_apply.sv
module boost_ctl_apply
  import boost_ctl_pkg::*;
#(
  parameter int BW   = 32,
  parameter int QW   = 48,
  parameter int STEP = 16000
) (
  input  breach_e       kind_i,
  input  logic [QW-1:0] quot_i,
  input  logic [BW-1:0] fmax_i,
  input  logic          above_i,
  input  logic          below_i,
  output logic [BW-1:0] boost_o,
  output logic          above_o,
  output logic          below_o
);
  localparam int HALF = STEP / 2;

  logic          wide;
  logic [BW-1:0] scaled;
  logic [BW:0]   grown;

  assign wide   = |quot_i[QW-1:BW];
  assign scaled = wide ? {BW{1'b1}} : quot_i[BW-1:0];
  assign grown  = {1'b0, scaled} + (BW+1)'(STEP);

  always_comb begin
    boost_o = scaled;
    above_o = above_i;
    below_o = below_i;
    if (kind_i == EV_UPPER) begin
      below_o = 1'b1;
      if (grown >= {1'b0, fmax_i}) begin
        boost_o = fmax_i;
        above_o = 1'b0;
      end else begin
        boost_o = grown[BW-1:0];
      end
    end else begin
      above_o = 1'b1;
      if (scaled < BW'(HALF)) begin
        boost_o = '0;
        below_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/boost_ctl.sv
module boost_ctl
  import boost_ctl_pkg::*;
#(
  parameter int BW      = 32,
  parameter int CW      = 16,
  parameter int STEP    = 16000,
  parameter int QDEPTH  = 4,
  parameter int PCT     = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          brk_up_i,
  input  logic          brk_dn_i,
  input  logic [CW-1:0] up_coeff_i,
  input  logic [CW-1:0] dn_coeff_i,
  input  logic [BW-1:0] fmax_i,
  output logic [BW-1:0] boost_o,
  output logic          above_en_o,
  output logic          below_en_o,
  output logic          done_o
);
  localparam int DW   = BW + CW;
  localparam int HALF = STEP / 2;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  ctl_state_e    state_q, state_d;
  breach_e       kind_q, kind_d;
  logic [BW-1:0] boost_q, boost_d;
  logic          above_q, above_d;
  logic          below_q, below_d;
  logic          done_q, done_d;

  logic          ev_push;
  breach_e       ev_kind;
  logic          q_empty;
  breach_e       q_head;
  logic          pop;
  logic [CW-1:0] coeff_sel;
  logic [DW-1:0] product;
  logic          div_busy;
  logic          div_done;
  logic [DW-1:0] div_quot;
  logic [BW-1:0] upd_boost;
  logic          upd_above;
  logic          upd_below;

  assign ev_push   = (brk_up_i || brk_dn_i) && !restart_i;
  assign ev_kind   = brk_up_i ? EV_UPPER : EV_LOWER;
  assign pop       = (state_q == ST_IDLE) && !q_empty && !restart_i;
  assign coeff_sel = (q_head == EV_UPPER) ? up_coeff_i : dn_coeff_i;
  assign product   = DW'(boost_q) * DW'(coeff_sel);

  boost_ctl_evq #(.DEPTH(QDEPTH)) u_evq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .flush_i     (restart_i),
    .push_i      (ev_push),
    .push_kind_i (ev_kind),
    .pop_i       (pop),
    .empty_o     (q_empty),
    .head_o      (q_head)
  );

  boost_ctl_div #(.DW(DW), .DIVISOR(PCT)) u_div (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .abort_i    (restart_i),
    .start_i    (pop),
    .dividend_i (product),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  boost_ctl_apply #(.BW(BW), .QW(DW), .STEP(STEP)) u_apply (
    .kind_i  (kind_q),
    .quot_i  (div_quot),
    .fmax_i  (fmax_i),
    .above_i (above_q),
    .below_i (below_q),
    .boost_o (upd_boost),
    .above_o (upd_above),
    .below_o (upd_below)
  );

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    boost_d = boost_q;
    above_d = above_q;
    below_d = below_q;
    done_d  = 1'b0;
    if (restart_i) begin
      state_d = ST_IDLE;
      boost_d = '0;
      above_d = 1'b1;
      below_d = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (pop) begin
            state_d = ST_SCALE;
            kind_d  = q_head;
          end
        end
        ST_SCALE: begin
          if (div_done) begin
            state_d = ST_IDLE;
            boost_d = upd_boost;
            above_d = upd_above;
            below_d = upd_below;
            done_d  = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      kind_q  <= EV_LOWER;
      boost_q <= '0;
      above_q <= 1'b1;
      below_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      boost_q <= boost_d;
      above_q <= above_d;
      below_q <= below_d;
      done_q  <= done_d;
    end
  end

  assign boost_o    = boost_q;
  assign above_en_o = above_q;
  assign below_en_o = below_q;
  assign done_o     = done_q;

  // R1: an applied upper event always arms the below interrupt
  a_r1_upper_arms_below: assert property (@(posedge clk) disable iff (!rst_n_int)
    (done_q && kind_q == EV_UPPER) |-> below_q);

  // R2: an upper result never exceeds the cap seen at update time
  a_r2_upper_capped: assert property (@(posedge clk) disable iff (!rst_n_int)
    (done_q && kind_q == EV_UPPER) |-> (boost_q <= $past(fmax_i)));

  // R3: an applied lower event always arms the above interrupt
  a_r3_lower_arms_above: assert property (@(posedge clk) disable iff (!rst_n_int)
    (done_q && kind_q == EV_LOWER) |-> above_q);

  // R4: a lower result is either zero or at least half a step
  a_r4_snap_gap: assert property (@(posedge clk) disable iff (!rst_n_int)
    (done_q && kind_q == EV_LOWER) |-> (boost_q == '0 || boost_q >= BW'(HALF)));

  // R4: a zero result from a lower event disarms the below interrupt
  a_r4_zero_disarms: assert property (@(posedge clk) disable iff (!rst_n_int)
    (done_q && kind_q == EV_LOWER && boost_q == '0) |-> !below_q);

  // R7: restart returns to the idle configuration
  a_r7_restart_state: assert property (@(posedge clk) disable iff (!rst_n_int)
    restart_i |=> (boost_q == '0 && above_q && !below_q && !done_q));

  // R9: boost moves only with a done pulse
  a_r9_boost_hold: assert property (@(posedge clk) disable iff (!rst_n_int)
    !restart_i |=> (done_q || $stable(boost_q)));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n_int)
    done_q |=> !done_q);

  // R8: the divider is only busy while an update is in progress
  a_r8_serial_update: assert property (@(posedge clk) disable iff (!rst_n_int)
    div_busy |-> (state_q == ST_SCALE));
endmodule

// File: tb/boost_ctl_bench.sv
`timescale 1ns/1ps
module boost_ctl_bench;
  localparam int DEPTH = 4;
  localparam int STEP  = 16000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        restart_i;
  logic        brk_up_i;
  logic        brk_dn_i;
  logic [15:0] up_coeff_i;
  logic [15:0] dn_coeff_i;
  logic [31:0] fmax_i;
  logic [31:0] boost_o;
  logic        above_en_o;
  logic        below_en_o;
  logic        done_o;

  always #2 clk = ~clk;

  boost_ctl u_boost_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart_i),
    .brk_up_i   (brk_up_i),
    .brk_dn_i   (brk_dn_i),
    .up_coeff_i (up_coeff_i),
    .dn_coeff_i (dn_coeff_i),
    .fmax_i     (fmax_i),
    .boost_o    (boost_o),
    .above_en_o (above_en_o),
    .below_en_o (below_en_o),
    .done_o     (done_o)
  );

  int          n_vec = 0;
  int          n_bad = 0;
  int          n_done = 0;
  bit          mon_en = 0;
  bit          prev_done = 0;
  bit          mq[$];
  logic [31:0] m_boost;
  bit          m_above;
  bit          m_below;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_apply(input bit up, output string tag);
    longint unsigned prod;
    longint unsigned q;
    longint unsigned s;
    bit sat;
    prod = longint'(m_boost) * longint'(up ? up_coeff_i : dn_coeff_i);
    q    = prod / 100;
    sat  = (q > 64'hFFFF_FFFF);
    if (sat) q = 64'hFFFF_FFFF;
    if (up) begin
      s = q + STEP;
      m_below = 1;
      if (s >= longint'(fmax_i)) begin
        m_boost = fmax_i; m_above = 0; tag = "R2";
      end else begin
        m_boost = s[31:0]; tag = "R1";
      end
    end else begin
      m_above = 1;
      if (q < STEP / 2) begin
        m_boost = 0; m_below = 0; tag = "R4";
      end else begin
        m_boost = q[31:0]; tag = "R3";
      end
    end
    if (sat) tag = "R6";
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (done_o) begin
        string tag;
        n_done++;
        if (prev_done) check("R9", "done width", 32'd2, 32'd1);
        if (mq.size() == 0) begin
          check("R8", "unexpected done", 32'd1, 32'd0);
        end else begin
          bit k;
          k = mq.pop_front();
          model_apply(k, tag);
          check(tag, "boost", boost_o, m_boost);
          check(tag, "above_en", {31'd0, above_en_o}, {31'd0, m_above});
          check(tag, "below_en", {31'd0, below_en_o}, {31'd0, m_below});
        end
      end
      prev_done = done_o;
    end
  end

  task automatic model_restart();
    mq.delete();
    m_boost = 0; m_above = 1; m_below = 0;
  endtask

  // mode 0: random kinds, 1: all upper, 2: both strobes, 3: all lower
  task automatic burst(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      bit u;
      bit d;
      @(negedge clk);
      case (mode)
        1:       begin u = 1; d = 0; end
        2:       begin u = 1; d = 1; end
        3:       begin u = 0; d = 1; end
        default: begin
          int r;
          r = $urandom_range(0, 9);
          u = (r < 5) || (r == 9);
          d = (r >= 5);
        end
      endcase
      brk_up_i = u;
      brk_dn_i = d;
      if (i < DEPTH + 1) mq.push_back(u);
    end
    @(negedge clk);
    brk_up_i = 0;
    brk_dn_i = 0;
  endtask

  task automatic settle();
    logic [31:0] snap;
    while (mq.size() != 0) @(negedge clk);
    @(negedge clk);
    snap = boost_o;
    repeat (70) @(negedge clk);
    check("R9", "boost held while idle", boost_o, snap);
    check("R8", "pending model entries", mq.size(), 0);
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart_i = 1;
    model_restart();
    @(negedge clk);
    restart_i = 0;
    check("R7", "boost after restart", boost_o, 32'd0);
    check("R7", "above after restart", {31'd0, above_en_o}, 32'd1);
    check("R7", "below after restart", {31'd0, below_en_o}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    int d0;
    seed = $urandom(32'd2024);
    rst_n = 0; restart_i = 0; brk_up_i = 0; brk_dn_i = 0;
    up_coeff_i = 16'd200; dn_coeff_i = 16'd50; fmax_i = 32'd1000000;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_restart();
    check("R7", "reset boost", boost_o, 32'd0);
    check("R7", "reset above", {31'd0, above_en_o}, 32'd1);
    check("R7", "reset below", {31'd0, below_en_o}, 32'd0);
    check("R9", "reset done", {31'd0, done_o}, 32'd0);
    mon_en = 1;

    // R1 then R4: grow from zero, then snap back
    burst(1, 1); settle();
    check("R1", "first step", boost_o, 32'd16000);
    dn_coeff_i = 16'd40;
    burst(1, 3); settle();
    check("R4", "snap to zero", boost_o, 32'd0);

    // R2: clamp at a low cap
    fmax_i = 32'd20000;
    burst(1, 1); burst(0, 1); settle();
    burst(1, 1); settle();
    check("R2", "clamped", boost_o, 32'd20000);
    check("R2", "above cleared", {31'd0, above_en_o}, 32'd0);

    // R5: both strobes in one cycle count as one upper event
    do_restart();
    fmax_i = 32'd1000000;
    d0 = n_done;
    burst(1, 2); settle();
    check("R5", "upper wins", boost_o, 32'd16000);
    check("R5", "one update", n_done - d0, 32'd1);

    // R8: long burst from idle, overflow drops the tail
    do_restart();
    up_coeff_i = 16'd100;
    d0 = n_done;
    burst(7, 1); settle();
    check("R8", "queued order result", boost_o, 32'd80000);
    check("R8", "updates from burst", n_done - d0, 32'd5);

    // R6: drive to 2^32-1 then overshoot the product
    do_restart();
    fmax_i = 32'hFFFF_FFFF; up_coeff_i = 16'd800;
    for (int i = 0; i < 8; i++) begin burst(1, 1); settle(); end
    check("R6", "saturated by growth", boost_o, 32'hFFFF_FFFF);
    dn_coeff_i = 16'hFFFF;
    burst(1, 3); settle();
    check("R6", "saturated product", boost_o, 32'hFFFF_FFFF);

    // R7: restart during an update and with a coincident strobe
    up_coeff_i = 16'd150; dn_coeff_i = 16'd60;
    burst(3, 0);
    repeat (10) @(negedge clk);
    do_restart();
    repeat (120) @(negedge clk);
    check("R7", "no update after abort", boost_o, 32'd0);
    @(negedge clk);
    restart_i = 1; brk_up_i = 1;
    model_restart();
    @(negedge clk);
    restart_i = 0; brk_up_i = 0;
    repeat (120) @(negedge clk);
    check("R7", "coincident strobe dropped", boost_o, 32'd0);

    // random phases
    for (int p = 0; p < 40; p++) begin
      up_coeff_i = 16'($urandom_range(0, 1000));
      dn_coeff_i = 16'($urandom_range(0, 130));
      case ($urandom_range(0, 2))
        0:       fmax_i = $urandom_range(20000, 2000000);
        1:       fmax_i = 32'hFFFF_FFFF;
        default: fmax_i = $urandom;
      endcase
      if ($urandom_range(0, 7) == 0) do_restart();
      for (int b = 0; b < 4; b++) begin
        burst($urandom_range(1, 6), 0);
        settle();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule